// File: doc/BRIEF.md
# Compare Event Timer

This block is one timer channel for generating timer events. It gives either a steady train of periodic ticks or a single deadline that fires once. An up-counter advances on a selectable count-enable input. When the count equals the programmed compare value, the channel records a compare event. In periodic operation the count then returns to zero and keeps running. In one-shot operation the count returns to zero and the channel switches itself off. Each one-shot is armed by a command that enables the channel and restarts the count in the same write.

Software reaches the channel through a small register port with eight word addresses: mode, compare, command, interrupt-mask set, interrupt-mask clear, mask readback, status (cleared on read) and the live count. Two latched event flags can drive the single interrupt output: a compare match and a counter wrap past all-ones. The count-enable inputs are supplied by the surrounding clock logic, for example a divided main clock and a 32768 Hz slow tick. A mode field picks which of them drives the counter. For a periodic tick rate T from a source of frequency F, software loads the compare register with round(F/T) - 1, because the period is compare + 1 ticks.

Top module: `compare_event_timer`

## Requirements
- R1: After a synchronous active-low reset the count is 0, the channel is disabled, mode is 0, compare is all ones, the mask and both flags are 0, and irq_o is low.
- R2: While the channel is enabled, the count rises by one in each cycle in which the selected count-enable input is high. While the channel is disabled, the count does not change unless a trigger is written.
- R3: Mode bits [SEL_W:1] choose which count-enable input is used (0 selects tick_i[0], 1 selects tick_i[1]). High levels on the inputs that are not selected have no effect on the count.
- R4: On a counting cycle in which the count equals compare, the count goes to 0, the compare flag (status bit 0) is set, and counting continues. With mode bit 0 clear, events therefore repeat every compare + 1 ticks.
- R5: With mode bit 0 set, a compare event also disables the channel, so the count stays at 0 until the next command.
- R6: A write to address 2 is a command: bit 0 enables, bit 1 disables, bit 2 triggers. Enable together with trigger restarts from 0 and counts from the next cycle. Disable freezes the count. Disable wins over enable. A command carrying trigger or disable suppresses counting in its own cycle.
- R7: A trigger written while the channel is disabled (and not enabled by the same write) sets the count to 0 and leaves the channel disabled.
- R8: On a counting cycle with the count at all ones and not equal to compare, the count wraps to 0 and the wrap flag (status bit 1) is set.
- R9: Address 6 reads the flags in bits 1:0 and the channel-enabled state in bit 4. A read there clears both flags at the end of the read cycle. A flag whose event happens in that same cycle stays set.
- R10: A write to address 3 sets the mask bits that are 1 in data bits 1:0. A write to address 4 clears them, so writing 0xFF masks every source. Address 5 reads the mask back.
- R11: irq_o is high exactly when some flag is set and its mask bit is set.
- R12: Address 0 reads the mode, address 1 reads compare, and address 7 reads the count. Addresses 2, 3 and 4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| tick_i | input | N_TICK | Count-enable inputs, one per clock source |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (clears status on address 6) |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the channel with CNT_W = 8 and N_TICK = 2. The 8-bit counter lets the wrap flag be reached after a couple of hundred ticks. With a 16-bit counter this would take tens of thousands of cycles. An 8-bit data path still holds the 0xFF mask-clear word and the enabled bit of the status word. With two count-enable inputs, the selection field is a single bit, and the bench can show that ticks on the input not selected are ignored.

// File: rtl/cet_pkg.sv
// Package: cet_pkg
// Shared constants and types of the compare event timer.
// Assumes a word-addressed register port of eight locations.
package cet_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE = 3'd0,
        A_CMP  = 3'd1,
        A_CMD  = 3'd2,
        A_IEN  = 3'd3,
        A_IDIS = 3'd4,
        A_MASK = 3'd5,
        A_STAT = 3'd6,
        A_CNT  = 3'd7
    } reg_addr_e;

    localparam int CMD_EN_BIT   = 0;
    localparam int CMD_DIS_BIT  = 1;
    localparam int CMD_TRIG_BIT = 2;

    localparam int N_SRC       = 2;
    localparam int SRC_CMP     = 0;
    localparam int SRC_OVF     = 1;
    localparam int STAT_EN_BIT = 4;

    typedef struct packed {
        logic en;
        logic dis;
        logic trig;
    } cmd_t;

endpackage

// File: rtl/cet_regs.sv
// Module: cet_regs
// Holds the mode and compare registers, decodes the command and mask
// strobes, and builds the read data. Assumes CNT_W >= 8 so the status
// word fits. Reads have no side effect except the status strobe.
module cet_regs
    import cet_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  bus_wr_i,
    input  logic                  bus_rd_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [CNT_W-1:0]      bus_wdata_i,
    input  logic [CNT_W-1:0]      cnt_i,
    input  logic                  en_i,
    input  logic [N_SRC-1:0]      flags_i,
    input  logic [N_SRC-1:0]      mask_i,
    output logic                  stop_mode_o,
    output logic [SEL_W-1:0]      clk_sel_o,
    output logic [CNT_W-1:0]      cmp_o,
    output cmd_t                  cmd_o,
    output logic [N_SRC-1:0]      mask_set_o,
    output logic [N_SRC-1:0]      mask_clr_o,
    output logic                  stat_rd_o,
    output logic [CNT_W-1:0]      bus_rdata_o
);

    localparam int MODE_W = SEL_W + 1;

    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  cmp_q;
    logic              cmd_hit;

    // Store mode and compare on writes to their addresses.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q <= '0;
            cmp_q  <= '1;
        end else if (bus_wr_i) begin
            if (bus_addr_i == A_MODE) mode_q <= bus_wdata_i[MODE_W-1:0];
            if (bus_addr_i == A_CMP)  cmp_q  <= bus_wdata_i;
        end
    end

    assign stop_mode_o = mode_q[0];
    assign clk_sel_o   = mode_q[MODE_W-1:1];
    assign cmp_o       = cmp_q;

    // Decode the one-cycle command and mask strobes.
    always_comb begin
        cmd_hit    = bus_wr_i && (bus_addr_i == A_CMD);
        cmd_o.en   = cmd_hit && bus_wdata_i[CMD_EN_BIT];
        cmd_o.dis  = cmd_hit && bus_wdata_i[CMD_DIS_BIT];
        cmd_o.trig = cmd_hit && bus_wdata_i[CMD_TRIG_BIT];
        mask_set_o = (bus_wr_i && bus_addr_i == A_IEN)  ? bus_wdata_i[N_SRC-1:0] : '0;
        mask_clr_o = (bus_wr_i && bus_addr_i == A_IDIS) ? bus_wdata_i[N_SRC-1:0] : '0;
        stat_rd_o  = bus_rd_i && (bus_addr_i == A_STAT);
    end

    // Select the read word for the addressed location.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_MODE: bus_rdata_o[MODE_W-1:0] = mode_q;
            A_CMP:  bus_rdata_o = cmp_q;
            A_MASK: bus_rdata_o[N_SRC-1:0] = mask_i;
            A_STAT: begin
                bus_rdata_o[N_SRC-1:0]   = flags_i;
                bus_rdata_o[STAT_EN_BIT] = en_i;
            end
            A_CNT:  bus_rdata_o = cnt_i;
            default: bus_rdata_o = '0;
        endcase
    end

    // R12
    cmp_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == A_CMP) |=> (cmp_o == $past(bus_wdata_i)));

endmodule

// File: rtl/cet_counter.sv
// Module: cet_counter
// Up-counter with compare, periodic or one-shot restart, enable state
// and command handling. Assumes at most one command per cycle. A command
// carrying trigger or disable takes the cycle and no counting occurs.
module cet_counter
    import cet_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_TICK = 2,
    parameter int SEL_W  = 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_TICK-1:0]  tick_i,
    input  logic [SEL_W-1:0]   clk_sel_i,
    input  logic               stop_mode_i,
    input  logic [CNT_W-1:0]   cmp_i,
    input  cmd_t               cmd_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               en_o,
    output logic [N_SRC-1:0]   ev_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    logic             tick_sel;
    logic             halt;
    logic             adv;
    logic             hit;
    logic             at_top;

    // Pick the count-enable input named by the select field.
    always_comb begin
        tick_sel = 1'b0;
        for (int i = 0; i < N_TICK; i++) begin
            if (clk_sel_i == SEL_W'(i)) tick_sel = tick_i[i];
        end
    end

    // Work out whether this cycle counts and which events it raises.
    always_comb begin
        halt   = cmd_i.dis || cmd_i.trig;
        adv    = en_q && tick_sel && !halt;
        hit    = (cnt_q == cmp_i);
        at_top = (cnt_q == {CNT_W{1'b1}});
        ev_o          = '0;
        ev_o[SRC_CMP] = adv && hit;
        ev_o[SRC_OVF] = adv && !hit && at_top;
    end

    // Advance, wrap on compare, or restart on trigger.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)         cnt_q <= '0;
        else if (cmd_i.trig) cnt_q <= '0;
        else if (adv)        cnt_q <= hit ? '0 : cnt_q + CNT_W'(1);
    end

    // Track whether the channel is running.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                        en_q <= 1'b0;
        else if (cmd_i.dis)                 en_q <= 1'b0;
        else if (cmd_i.en)                  en_q <= 1'b1;
        else if (adv && hit && stop_mode_i) en_q <= 1'b0;
    end

    assign cnt_o = cnt_q;
    assign en_o  = en_q;

    // R5
    oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_o[SRC_CMP] && stop_mode_i && !cmd_i.en) |=> !en_q);

    // R4
    periodic_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_o[SRC_CMP] |=> (cnt_q == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_q && !cmd_i.trig) |=> $stable(cnt_q));

    // R7
    trig_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i.trig && !en_q && !cmd_i.en) |=> (cnt_q == '0 && !en_q));

endmodule

// File: rtl/cet_irq.sv
// Module: cet_irq
// Latches each event source into a status flag that a status read
// clears, keeps the interrupt mask, and drives the interrupt request.
// Assumes set and clear strobes of the mask never arrive together.
module cet_irq
    import cet_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] ev_i,
    input  logic             stat_rd_i,
    input  logic [N_SRC-1:0] mask_set_i,
    input  logic [N_SRC-1:0] mask_clr_i,
    output logic [N_SRC-1:0] flags_o,
    output logic [N_SRC-1:0] mask_o,
    output logic             irq_o
);

    logic [N_SRC-1:0] flag_q;
    logic [N_SRC-1:0] mask_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        // Latch the event; a new event beats a clearing read.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)        flag_q[g] <= 1'b0;
            else if (ev_i[g])   flag_q[g] <= 1'b1;
            else if (stat_rd_i) flag_q[g] <= 1'b0;
        end

        // Set or clear this source's mask bit.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)            mask_q[g] <= 1'b0;
            else if (mask_set_i[g]) mask_q[g] <= 1'b1;
            else if (mask_clr_i[g]) mask_q[g] <= 1'b0;
        end

        // R9
        flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ev_i[g] |=> flag_q[g]);
    end

    assign flags_o = flag_q;
    assign mask_o  = mask_q;
    assign irq_o   = |(flag_q & mask_q);

    // R10
    mask_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_clr_i == '1) |=> !irq_o);

endmodule

// File: rtl/compare_event_timer.sv
// Module: compare_event_timer
// Timer channel top: register port, counter with compare and one-shot
// stop, status flags and interrupt. Assumes the tick inputs are already
// synchronous one-cycle count enables in the clk_i domain.
module compare_event_timer
    import cet_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_TICK = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_TICK-1:0]  tick_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [2:0]         bus_addr_i,
    input  logic [CNT_W-1:0]   bus_wdata_i,
    output logic [CNT_W-1:0]   bus_rdata_o,
    output logic               irq_o
);

    localparam int SEL_W = (N_TICK > 1) ? $clog2(N_TICK) : 1;

    logic             stop_mode;
    logic [SEL_W-1:0] clk_sel;
    logic [CNT_W-1:0] cmp_val;
    cmd_t             cmd;
    logic [N_SRC-1:0] mask_set;
    logic [N_SRC-1:0] mask_clr;
    logic             stat_rd;
    logic [CNT_W-1:0] cnt;
    logic             en;
    logic [N_SRC-1:0] ev;
    logic [N_SRC-1:0] flags;
    logic [N_SRC-1:0] mask;

    cet_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_wr_i    (bus_wr_i),
        .bus_rd_i    (bus_rd_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .cnt_i       (cnt),
        .en_i        (en),
        .flags_i     (flags),
        .mask_i      (mask),
        .stop_mode_o (stop_mode),
        .clk_sel_o   (clk_sel),
        .cmp_o       (cmp_val),
        .cmd_o       (cmd),
        .mask_set_o  (mask_set),
        .mask_clr_o  (mask_clr),
        .stat_rd_o   (stat_rd),
        .bus_rdata_o (bus_rdata_o)
    );

    cet_counter #(.CNT_W(CNT_W), .N_TICK(N_TICK), .SEL_W(SEL_W)) u_counter (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .clk_sel_i   (clk_sel),
        .stop_mode_i (stop_mode),
        .cmp_i       (cmp_val),
        .cmd_i       (cmd),
        .cnt_o       (cnt),
        .en_o        (en),
        .ev_o        (ev)
    );

    cet_irq u_irq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ev_i       (ev),
        .stat_rd_i  (stat_rd),
        .mask_set_i (mask_set),
        .mask_clr_i (mask_clr),
        .flags_o    (flags),
        .mask_o     (mask),
        .irq_o      (irq_o)
    );

    // R8
    wrap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev[SRC_OVF] |=> (cnt == '0 && flags[SRC_OVF]));

endmodule

// File: tb/compare_event_timer_tb.sv
module compare_event_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   tick = '0;
    logic         wr = 1'b0;
    logic         rd = 1'b0;
    logic [2:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    compare_event_timer #(.CNT_W(W), .N_TICK(2)) u_dut (
        .clk_i (clk), .rst_ni (rst_n), .tick_i (tick),
        .bus_wr_i (wr), .bus_rd_i (rd), .bus_addr_i (addr),
        .bus_wdata_i (wdata), .bus_rdata_o (rdata), .irq_o (irq)
    );

    // Behavioural reference model of the requirements.
    logic         m_stop, m_sel, m_en;
    logic [W-1:0] m_cmp, m_cnt;
    logic [1:0]   m_mask, m_flag;
    logic         m_ts, m_halt, m_adv, m_ec, m_eo;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stop = 0; m_sel = 0; m_en = 0; m_cmp = TOP; m_cnt = 0;
            m_mask = 0; m_flag = 0;
        end else begin
            m_ts   = tick[m_sel];
            m_halt = wr && addr == 3'd2 && (wdata[1] || wdata[2]);
            m_adv  = m_en && m_ts && !m_halt;
            m_ec   = m_adv && (m_cnt == m_cmp);
            m_eo   = m_adv && (m_cnt != m_cmp) && (m_cnt == TOP);
            if (wr && addr == 3'd2 && wdata[1])      m_en = 0;
            else if (wr && addr == 3'd2 && wdata[0]) m_en = 1;
            else if (m_ec && m_stop)                 m_en = 0;
            if (wr && addr == 3'd2 && wdata[2]) m_cnt = 0;
            else if (m_adv) m_cnt = m_ec ? '0 : m_cnt + 1'b1;
            if (rd && addr == 3'd6) m_flag = 0;
            if (m_ec) m_flag[0] = 1;
            if (m_eo) m_flag[1] = 1;
            if (wr && addr == 3'd3) m_mask = m_mask | wdata[1:0];
            if (wr && addr == 3'd4) m_mask = m_mask & ~wdata[1:0];
            if (wr && addr == 3'd0) begin m_stop = wdata[0]; m_sel = wdata[1]; end
            if (wr && addr == 3'd1) m_cmp = wdata;
        end
    end

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare outputs with the model on every cycle.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [W-1:0] exp_rd;
            exp_rd = '0;
            case (addr)
                3'd0: exp_rd = {{(W-2){1'b0}}, m_sel, m_stop};
                3'd1: exp_rd = m_cmp;
                3'd5: exp_rd = {{(W-2){1'b0}}, m_mask};
                3'd6: exp_rd = {{(W-5){1'b0}}, m_en, 2'b00, m_flag};
                3'd7: exp_rd = m_cnt;
                default: exp_rd = '0;
            endcase
            check("R11 model irq", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, |(m_flag & m_mask)});
            check("R12 model rdata", rdata, exp_rd);
        end
    end

    task automatic cyc(input logic w, input logic r, input logic [2:0] a,
                       input logic [W-1:0] d, input logic [1:0] t);
        @(posedge clk); #1;
        wr = w; rd = r; addr = a; wdata = d; tick = t;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 3'd0, '0, 2'b00);
    endtask

    task automatic ticks(input int n, input logic [1:0] t);
        for (int i = 0; i < n; i++) cyc(0, 0, 3'd0, '0, t);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [W-1:0] d);
        cyc(1, 0, a, d, 2'b00);
    endtask

    task automatic chk_rd(input logic [2:0] a, input logic [W-1:0] exp, input string tag,
                          input logic [1:0] t = 2'b00);
        cyc(0, 1, a, '0, t);
        @(negedge clk);
        check(tag, rdata, exp);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        idle(1);
        @(negedge clk);
        check(tag, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(posedge clk); #1; rst_n = 1;
        // R1 reset state
        chk_rd(3'd1, 8'hFF, "R1 compare reset");
        chk_rd(3'd7, 8'h00, "R1 count reset");
        chk_rd(3'd6, 8'h00, "R1 status reset");
        chk_rd(3'd5, 8'h00, "R1 mask reset");
        chk_rd(3'd0, 8'h00, "R1 mode reset");
        chk_irq(1'b0, "R1 irq reset");

        // Periodic operation
        wreg(3'd1, 8'd4);
        wreg(3'd3, 8'h01);
        wreg(3'd2, 8'h05);
        ticks(3, 2'b01);
        chk_rd(3'd7, 8'd3, "R2 count after three ticks");
        ticks(2, 2'b10);
        chk_rd(3'd7, 8'd3, "R3 unselected ticks ignored");
        ticks(2, 2'b01);
        chk_rd(3'd7, 8'd0, "R4 wrap at compare");
        chk_irq(1'b1, "R11 irq on masked-in flag");
        chk_rd(3'd6, 8'h11, "R9 status with flag and enabled");
        chk_rd(3'd6, 8'h10, "R9 flag cleared by read");
        chk_irq(1'b0, "R11 irq low after clear");
        ticks(4, 2'b01);
        chk_rd(3'd6, 8'h10, "R4 no event before period");
        ticks(1, 2'b01);
        chk_rd(3'd6, 8'h11, "R4 event after compare+1 ticks");
        chk_rd(3'd2, 8'h00, "R12 command reads zero");

        // Clock select
        wreg(3'd0, 8'h02);
        wreg(3'd2, 8'h05);
        ticks(3, 2'b01);
        chk_rd(3'd7, 8'd0, "R3 source 0 ignored when 1 selected");
        ticks(2, 2'b10);
        chk_rd(3'd7, 8'd2, "R3 source 1 counts");
        chk_rd(3'd0, 8'h02, "R12 mode readback");

        // One-shot
        wreg(3'd0, 8'h01);
        wreg(3'd1, 8'd2);
        chk_rd(3'd6, 8'h10, "R9 clear before one-shot");
        wreg(3'd2, 8'h05);
        ticks(5, 2'b01);
        chk_rd(3'd7, 8'd0, "R5 count parked at zero");
        chk_rd(3'd6, 8'h01, "R5 channel disabled after event");
        chk_irq(1'b0, "R9 irq cleared by the status read");

        // Disable, trigger while disabled, disable beats enable
        wreg(3'd0, 8'h00);
        wreg(3'd2, 8'h01);
        ticks(2, 2'b01);
        wreg(3'd2, 8'h02);
        ticks(3, 2'b01);
        chk_rd(3'd7, 8'd2, "R6 disable freezes count");
        wreg(3'd2, 8'h04);
        ticks(2, 2'b01);
        chk_rd(3'd7, 8'd0, "R7 trigger resets count");
        chk_rd(3'd6, 8'h00, "R7 channel still disabled");
        wreg(3'd2, 8'h03);
        chk_rd(3'd6, 8'h00, "R6 disable wins over enable");

        // Wrap past all ones
        wreg(3'd1, 8'hFF);
        wreg(3'd2, 8'h05);
        ticks(10, 2'b01);
        wreg(3'd1, 8'd5);
        ticks(245, 2'b01);
        chk_rd(3'd7, 8'hFF, "R8 count at top");
        ticks(1, 2'b01);
        chk_rd(3'd7, 8'h00, "R8 wrapped to zero");
        chk_irq(1'b0, "R11 wrap flag masked out");
        wreg(3'd3, 8'h02);
        chk_irq(1'b1, "R10 set wrap mask raises irq");
        chk_rd(3'd5, 8'h03, "R10 mask readback");
        wreg(3'd4, 8'hFF);
        chk_irq(1'b0, "R10 0xFF clear masks all");
        chk_rd(3'd5, 8'h00, "R10 mask cleared");
        chk_rd(3'd6, 8'h12, "R8 wrap flag in status");

        // Read in the same cycle as an event
        ticks(5, 2'b01);
        chk_rd(3'd6, 8'h10, "R9 read during event", 2'b01);
        chk_rd(3'd6, 8'h11, "R9 event survives same-cycle read");

        // Mixed stimulus against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[2:0] == 3'd0, r[4:3] == 2'd0, r[7:5], r[15:8], r[17:16]);
        end
        idle(2);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule